// File: doc/BRIEF.md
# Lane Alignment Sequence Generator

This block drives one transmit lane of a multi-lane serial converter link during link bring-up. Each link clock it presents a 32-bit word of four octets together with a 4-bit flag that marks which octets are control characters. While the receiver holds its active-low synchronisation request, the lane sends the comma character /K/ on every octet. Once the request is released, the block waits for the next multiframe boundary. It then sends an alignment sequence of exactly four multiframes and passes user data through after that.

Every alignment multiframe opens with /R/ and closes with /A/. The second multiframe also carries /Q/ right after its /R/, followed by 14 link-configuration octets taken from a register input. All other alignment octets carry a ramp equal to the octet's position in the multiframe. Octets per frame (F) and frames per multiframe (K) are parameters. F×K must be a multiple of 4 and at least 20, so /R/ always falls in octet 0 of a word. A free-running word counter, cleared by reset, marks the multiframe boundaries. It wraps every F×K/4 cycles.

Top module: `ilas_gen`

## Requirements
- R1: During reset and in the first cycle after it, every octet is 0xBC with all four flags set, and `ilas_done` is low.
- R2: In any cycle that follows a clock edge where `sync_n` was sampled low, the word is 0xBCBCBCBC with flags 4'b1111.
- R3: The alignment sequence begins only on a multiframe boundary. This is the cycle in which the word counter returns to 0, every F×K/4 cycles counted from reset release. It begins at the first such boundary where `sync_n` was high at the preceding edge.
- R4: Octet 0 of every alignment multiframe is 0x1C (/R/) with its flag set. Octet k of a word is carried in bits [8k+7:8k] and flagged by bit k, and octet 0 is sent first.
- R5: The last octet of every alignment multiframe (position F×K−1) is 0x7C (/A/) with its flag set.
- R6: In the second multiframe, position 1 is 0x9C (/Q/) with its flag set. Positions 2 to 15 carry `cfg_octets[8n+7:8n]` for n = position−2, with their flags clear.
- R7: Every other alignment octet equals its position within the multiframe, modulo 256, with its flag clear.
- R8: Exactly four multiframes are sent. The word right after the one holding the fourth /A/ is `user_data`, and it is passed through with all flags clear for as long as `sync_n` stays high.
- R9: `ilas_done` is high for exactly one cycle, the first user-data cycle.
- R10: If `sync_n` is sampled low during the alignment sequence or user data, the next word is /K/ and a new sequence starts as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_n | input | 1 | Receiver synchronisation request, active low |
| cfg_octets | input | 112 | 14 configuration octets, octet n in bits [8n+7:8n] |
| user_data | input | 32 | User payload word, octet 0 in bits [7:0] |
| tx_data | output | 32 | Lane word, octet 0 in bits [7:0] |
| tx_kflag | output | 4 | Per-octet control-character flag |
| ilas_done | output | 1 | One-cycle pulse on entry to user data |

## Verification
The bench releases the sync request at random offsets from the multiframe boundary. A design that starts the sequence on the release itself, rather than on the next boundary, would put /R/ in the wrong cycle. The bench also counts multiframes exactly, so a fifth or a missing /A/ would show up as user data arriving one multiframe late or early. It drops `sync_n` partway through the alignment sequence and during user data. A design that ignored the drop would keep emitting ramp or payload where /K/ is due. The configuration octets change on every episode and are compared by position, which catches an off-by-one or a reversed octet order in the second multiframe.

// File: rtl/ilas_gen.sv
module ilas_gen #(
  parameter int F = 2,
  parameter int K = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sync_n,
  input  logic [111:0] cfg_octets,
  input  logic [31:0]  user_data,
  output logic [31:0]  tx_data,
  output logic [3:0]   tx_kflag,
  output logic         ilas_done
);
  localparam int MF_OCT = F * K;
  localparam int WPM    = MF_OCT / 4;
  localparam int WW     = $clog2(WPM);
  localparam int OW     = WW + 2;

  if (MF_OCT % 4 != 0 || MF_OCT < 20) begin : g_bad_len
    $error("multiframe length must be a multiple of 4 and at least 20");
  end

  typedef enum logic [1:0] {S_SYNC, S_ILAS, S_DATA} st_t;

  st_t           st;
  logic [WW-1:0] wcnt;
  logic [1:0]    mf;
  logic          last;
  logic [7:0]    cfg_arr [16];

  assign last = (wcnt == WW'(WPM - 1));

  for (genvar n = 0; n < 16; n++) begin : g_cfg
    if (n < 14) begin : g_on
      assign cfg_arr[n] = cfg_octets[8*n +: 8];
    end else begin : g_pad
      assign cfg_arr[n] = 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_SYNC;
      wcnt      <= '0;
      mf        <= '0;
      ilas_done <= 1'b0;
    end else begin
      wcnt      <= last ? '0 : wcnt + 1'b1;
      ilas_done <= (st == S_ILAS) && sync_n && last && (mf == 2'd3);
      case (st)
        S_SYNC: if (sync_n && last) begin
          st <= S_ILAS;
          mf <= '0;
        end
        S_ILAS: begin
          if (!sync_n) st <= S_SYNC;
          else if (last) begin
            if (mf == 2'd3) st <= S_DATA;
            else mf <= mf + 1'b1;
          end
        end
        default: if (!sync_n) st <= S_SYNC;
      endcase
    end
  end

  for (genvar j = 0; j < 4; j++) begin : g_oct
    logic [OW-1:0] pos;
    logic [3:0]    cidx;
    assign pos  = {wcnt, 2'(j)};
    assign cidx = 4'(pos - OW'(2));

    always_comb begin
      tx_data[8*j +: 8] = 8'(pos);
      tx_kflag[j]       = 1'b0;
      if (st == S_SYNC) begin
        tx_data[8*j +: 8] = 8'hBC;
        tx_kflag[j]       = 1'b1;
      end else if (st == S_DATA) begin
        tx_data[8*j +: 8] = user_data[8*j +: 8];
      end else if (pos == '0) begin
        tx_data[8*j +: 8] = 8'h1C;
        tx_kflag[j]       = 1'b1;
      end else if (pos == OW'(MF_OCT - 1)) begin
        tx_data[8*j +: 8] = 8'h7C;
        tx_kflag[j]       = 1'b1;
      end else if (mf == 2'd1 && pos == OW'(1)) begin
        tx_data[8*j +: 8] = 8'h9C;
        tx_kflag[j]       = 1'b1;
      end else if (mf == 2'd1 && pos <= OW'(15)) begin
        tx_data[8*j +: 8] = cfg_arr[cidx];
      end
    end
  end
endmodule

module ilas_gen_chk #(
  parameter int WPM = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     sync_n,
  input logic [31:0]              tx_data,
  input logic [3:0]               tx_kflag,
  input logic                     ilas_done,
  input logic                     st_ilas,
  input logic [$clog2(WPM)-1:0]   wcnt
);
  a_r2_k_on_request: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n |=> (tx_data == 32'hBCBCBCBC && tx_kflag == 4'hF));
  a_r3_start_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_ilas) |-> wcnt == '0);
  a_r4_r_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ilas && wcnt == '0) |-> (tx_data[7:0] == 8'h1C && tx_kflag[0]));
  a_r5_a_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ilas && wcnt == $clog2(WPM)'(WPM - 1)) |-> (tx_data[31:24] == 8'h7C && tx_kflag[3]));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    ilas_done |=> !ilas_done);
  a_r8_done_data: assert property (@(posedge clk) disable iff (!rst_n)
    ilas_done |-> (tx_kflag == 4'h0 && !st_ilas));
endmodule

bind ilas_gen ilas_gen_chk #(.WPM(WPM)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .tx_data(tx_data),
  .tx_kflag(tx_kflag), .ilas_done(ilas_done),
  .st_ilas(st == S_ILAS), .wcnt(wcnt)
);

// File: tb/ilas_gen_tb.sv
`timescale 1ns/1ps
module ilas_gen_tb;
  localparam int F = 2, K = 16, MF = F * K, WPM = MF / 4;

  logic         clk = 1'b0, rst_n = 1'b0, sync_n = 1'b0;
  logic [111:0] cfg_octets = '0;
  logic [31:0]  user_data = '0;
  logic [31:0]  tx_data;
  logic [3:0]   tx_kflag;
  logic         ilas_done;

  int total = 0, bad = 0, cyc = 0;
  bit run = 0, finished = 0;

  ilas_gen #(.F(F), .K(K)) u_dut (.*);

  always #2.5 clk = ~clk;

  // reference state: 0 = K, 1 = alignment, 2 = user data
  int m_st = 0, m_w = 0, m_mf = 0;
  bit m_done = 0, m_drop = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      m_st <= 0; m_w <= 0; m_mf <= 0; m_done <= 0; m_drop <= 0;
    end else begin
      m_w    <= (m_w == WPM - 1) ? 0 : m_w + 1;
      m_done <= (m_st == 1 && sync_n && m_w == WPM - 1 && m_mf == 3);
      m_drop <= (m_st != 0 && !sync_n);
      if (m_st == 0 && sync_n && m_w == WPM - 1) begin m_st <= 1; m_mf <= 0; end
      else if (m_st != 0 && !sync_n) m_st <= 0;
      else if (m_st == 1 && m_w == WPM - 1) begin
        if (m_mf == 3) m_st <= 2; else m_mf <= m_mf + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got k=%h d=%h expected k=%h d=%h at cycle %0d",
               tag, act[35:32], act[31:0], exp[35:32], exp[31:0], cyc);
    end
  endtask

  always begin
    @(negedge clk); #1;
    if (run && rst_n) begin
      logic [31:0] ed; logic [3:0] ek; string tag;
      ed = '0; ek = '0;
      if (m_st == 0) begin
        ed = 32'hBCBCBCBC; ek = 4'hF; tag = m_drop ? "R10" : "R2";
      end else if (m_st == 2) begin
        ed = user_data; tag = "R8";
      end else begin
        for (int j = 0; j < 4; j++) begin
          int p; p = m_w * 4 + j;
          if (p == 0) begin ed[8*j +: 8] = 8'h1C; ek[j] = 1; end
          else if (p == MF - 1) begin ed[8*j +: 8] = 8'h7C; ek[j] = 1; end
          else if (m_mf == 1 && p == 1) begin ed[8*j +: 8] = 8'h9C; ek[j] = 1; end
          else if (m_mf == 1 && p <= 15) ed[8*j +: 8] = cfg_octets[8*(p-2) +: 8];
          else ed[8*j +: 8] = 8'(p);
        end
        if (m_w == 0 && m_mf == 0) tag = "R3";
        else if (m_w == 0) tag = "R4";
        else if (m_w == WPM - 1) tag = "R5";
        else if (m_mf == 1 && m_w <= 3) tag = "R6";
        else tag = "R7";
      end
      chk(tag, {tx_kflag, tx_data}, {ek, ed});
      chk("R9", {35'd0, ilas_done}, {35'd0, m_done});
    end
  end

  initial begin
    int s;
    s = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    chk("R1", {tx_kflag, tx_data}, {4'hF, 32'hBCBCBCBC});
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {ilas_done, tx_kflag, tx_data}, {1'b0, 4'hF, 32'hBCBCBCBC});
    run = 1;
    for (int ep = 0; ep < 40; ep++) begin
      int hold, len;
      sync_n = 1'b0;
      for (int i = 0; i < 4; i++) cfg_octets[32*i +: 32] = $urandom;
      hold = (ep < 4) ? WPM - 1 + ep : 1 + $urandom % 12;
      repeat (hold) begin @(negedge clk); user_data = $urandom; end
      sync_n = 1'b1;
      if (ep % 4 == 1) len = 1 + $urandom % (5 * WPM);
      else len = 6 * WPM + $urandom % 20;
      repeat (len) begin @(negedge clk); user_data = $urandom; end
    end
    sync_n = 1'b0;
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule